// File: doc/BRIEF.md
# Early Depth Test with Deferred Depth Write

This block sits in the fragment stage of a rasteriser. Each fragment carries a pixel position, a 16-bit unsigned depth and the alpha value its texture will produce. On arrival the fragment is checked against a small on-chip depth buffer without writing it. A fragment that is already hidden is marked dead at once and never issues a texel fetch request. Surviving fragments raise a fetch request on the cycle after arrival. The fragment then travels through a fixed pipeline that stands in for texture latency.

At the end of that pipeline an alpha test discards fragments whose alpha is zero. The remaining fragments are tested against the depth buffer a second time, and only those that pass write their depth. Because the early test may see a buffer value that a fragment still in flight is about to replace, the late test sees every earlier fragment's write. This includes a write that is still held in the write-back register and not yet committed to the buffer.

Every fragment leaves in arrival order with a verdict naming the stage that killed it, or saying that it passed. A clear command sets the whole buffer back to the farthest depth.

Top module: `zdefer_top`

## Requirements
- R1: After reset, out_vld and tex_req are 0, and every depth-buffer entry holds all ones, so a fragment with depth 0xFFFE and non-zero alpha passes.
- R2: A fragment whose depth is greater than or equal to the committed buffer value at its arrival is killed with out_stage = 1 (early). A write becomes committed 6 cycles after its fragment arrives.
- R3: A fragment that survives the early test raises tex_req, with tex_x/tex_y equal to its position, exactly one cycle after arrival. An early-killed fragment raises no tex_req.
- R4: A fragment that survives the early test but has alpha equal to 0 is killed with out_stage = 2 (alpha) and leaves the depth buffer unchanged.
- R5: A fragment with non-zero alpha that passed the early test is killed with out_stage = 3 (late) when its depth is not less than the depth left by all earlier fragments, including those still in flight.
- R6: Any other fragment passes: out_pass = 1, out_stage = 0, and its depth replaces the buffer entry.
- R7: Each fragment produces exactly one output, TEX_LAT + 1 cycles after arrival, in arrival order, with its x/y. No output appears otherwise.
- R8: A clear pulse, given while no fragment is in flight, sets every buffer entry to all ones.
- R9: The compare is strictly less-than, so a fragment whose depth equals the stored depth fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Clear the depth buffer to all ones |
| in_vld | input | 1 | Fragment present this cycle |
| in_x | input | XW | Fragment column |
| in_y | input | YW | Fragment row |
| in_z | input | DW | Fragment depth, smaller is nearer |
| in_alpha | input | ABW | Texture alpha of the fragment |
| tex_req | output | 1 | Texel fetch request for an early survivor |
| tex_x | output | XW | Column of the fetch request |
| tex_y | output | YW | Row of the fetch request |
| out_vld | output | 1 | Verdict present |
| out_x | output | XW | Column of the retiring fragment |
| out_y | output | YW | Row of the retiring fragment |
| out_pass | output | 1 | Fragment survived all tests |
| out_stage | output | 2 | 0 pass, 1 early depth, 2 alpha, 3 late depth |

## Verification
The bench builds the block with its defaults: a 32 by 32 buffer, 16-bit depth, 8-bit alpha and a four-cycle texture gap. With a gap of four, fragments on one pixel that are one, two or five cycles apart fall into three different windows: served by the write-back bypass, served by the committed buffer at the late test, or stale at the early test. Directed runs of back-to-back fragments on one pixel cover each window. A random stream confined to a 4 by 4 corner then keeps those collisions frequent.

// File: rtl/zd_pkg.sv
package zd_pkg;

  typedef enum logic [1:0] {
    KILL_NONE  = 2'd0,
    KILL_EARLY = 2'd1,
    KILL_ALPHA = 2'd2,
    KILL_LATE  = 2'd3
  } kill_t;

  // depth compare: strictly less wins (smaller is nearer)
  function automatic logic z_nearer(input logic [31:0] cand, input logic [31:0] stored);
    return cand < stored;
  endfunction

  // alpha test: zero alpha means fully transparent, discard
  function automatic logic alpha_drop(input logic [31:0] a);
    return a == 32'd0;
  endfunction

endpackage

// File: rtl/zd_depth_buf.sv
module zd_depth_buf #(
  parameter int XW = 5,
  parameter int YW = 5,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic [XW+YW-1:0]     ea,
  output logic [DW-1:0]        ed,
  input  logic [XW+YW-1:0]     la,
  output logic [DW-1:0]        ld,
  input  logic                 we,
  input  logic [XW+YW-1:0]     wa,
  input  logic [DW-1:0]        wd
);
  localparam int AW   = XW + YW;
  localparam int NPIX = 1 << AW;

  logic [DW-1:0] cells [NPIX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPIX; i++) cells[i] <= '1;
    end else if (clr) begin
      for (int i = 0; i < NPIX; i++) cells[i] <= '1;
    end else if (we) begin
      cells[wa] <= wd;
    end
  end

  assign ed = cells[ea];
  assign ld = cells[la];

endmodule

// File: rtl/zd_delay_line.sv
module zd_delay_line #(
  parameter int W = 8,
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] st [N];

  for (genvar i = 0; i < N; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[0] <= '0;
        else        st[0] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[i] <= '0;
        else        st[i] <= st[i-1];
      end
    end
  end

  assign dout = st[N-1];

endmodule

// File: rtl/zd_late_stage.sv
module zd_late_stage
  import zd_pkg::*;
#(
  parameter int XW  = 5,
  parameter int YW  = 5,
  parameter int DW  = 16,
  parameter int ABW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_vld,
  input  logic               in_ek,
  input  logic [XW-1:0]      in_x,
  input  logic [YW-1:0]      in_y,
  input  logic [DW-1:0]      in_z,
  input  logic [ABW-1:0]     in_a,
  output logic [XW+YW-1:0]   rd_addr,
  input  logic [DW-1:0]      rd_z,
  output logic               out_vld,
  output logic [XW-1:0]      out_x,
  output logic [YW-1:0]      out_y,
  output logic               out_pass,
  output kill_t              out_stage,
  output logic               wb_vld,
  output logic [XW+YW-1:0]   wb_addr,
  output logic [DW-1:0]      wb_z
);
  localparam int AW = XW + YW;

  logic [DW-1:0] cur_z;
  logic          hit_pending;
  kill_t         verdict;

  assign rd_addr     = {in_y, in_x};
  assign hit_pending = wb_vld && (wb_addr == rd_addr);
  assign cur_z       = hit_pending ? wb_z : rd_z;

  always_comb begin
    if (in_ek)                                verdict = KILL_EARLY;
    else if (alpha_drop(32'(in_a)))           verdict = KILL_ALPHA;
    else if (!z_nearer(32'(in_z), 32'(cur_z))) verdict = KILL_LATE;
    else                                      verdict = KILL_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld   <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
      out_pass  <= 1'b0;
      out_stage <= KILL_NONE;
      wb_vld    <= 1'b0;
      wb_addr   <= '0;
      wb_z      <= '0;
    end else begin
      out_vld   <= in_vld;
      out_x     <= in_x;
      out_y     <= in_y;
      out_pass  <= in_vld && (verdict == KILL_NONE);
      out_stage <= in_vld ? verdict : KILL_NONE;
      wb_vld    <= in_vld && (verdict == KILL_NONE);
      wb_addr   <= AW'(rd_addr);
      wb_z      <= in_z;
    end
  end

endmodule

// File: rtl/zdefer_top.sv
module zdefer_top
  import zd_pkg::*;
#(
  parameter int XW      = 5,
  parameter int YW      = 5,
  parameter int DW      = 16,
  parameter int ABW     = 8,
  parameter int TEX_LAT = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           in_vld,
  input  logic [XW-1:0]  in_x,
  input  logic [YW-1:0]  in_y,
  input  logic [DW-1:0]  in_z,
  input  logic [ABW-1:0] in_alpha,
  output logic           tex_req,
  output logic [XW-1:0]  tex_x,
  output logic [YW-1:0]  tex_y,
  output logic           out_vld,
  output logic [XW-1:0]  out_x,
  output logic [YW-1:0]  out_y,
  output logic           out_pass,
  output logic [1:0]     out_stage
);
  localparam int AW = XW + YW;
  localparam int PW = 2 + XW + YW + DW + ABW;

  logic [DW-1:0]  early_z;
  logic           early_kill;
  logic [AW-1:0]  late_addr;
  logic [DW-1:0]  late_z_rd;
  logic           wb_vld;
  logic [AW-1:0]  wb_addr;
  logic [DW-1:0]  wb_z;
  logic [PW-1:0]  pipe_in;
  logic [PW-1:0]  pipe_out;
  logic           l_vld;
  logic           l_ek;
  logic [XW-1:0]  l_x;
  logic [YW-1:0]  l_y;
  logic [DW-1:0]  l_z;
  logic [ABW-1:0] l_a;
  kill_t          stage_q;

  zd_depth_buf #(.XW(XW), .YW(YW), .DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .ea({in_y, in_x}), .ed(early_z),
    .la(late_addr), .ld(late_z_rd),
    .we(wb_vld), .wa(wb_addr), .wd(wb_z)
  );

  // read-only early test
  assign early_kill = in_vld && !z_nearer(32'(in_z), 32'(early_z));

  // texel fetch request for early survivors
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tex_req <= 1'b0;
      tex_x   <= '0;
      tex_y   <= '0;
    end else begin
      tex_req <= in_vld && !early_kill;
      tex_x   <= in_x;
      tex_y   <= in_y;
    end
  end

  assign pipe_in = {in_vld, early_kill, in_x, in_y, in_z, in_alpha};

  zd_delay_line #(.W(PW), .N(TEX_LAT)) u_lat (
    .clk(clk), .rst_n(rst_n), .din(pipe_in), .dout(pipe_out)
  );

  assign {l_vld, l_ek, l_x, l_y, l_z, l_a} = pipe_out;

  zd_late_stage #(.XW(XW), .YW(YW), .DW(DW), .ABW(ABW)) u_late (
    .clk(clk), .rst_n(rst_n),
    .in_vld(l_vld), .in_ek(l_ek), .in_x(l_x), .in_y(l_y), .in_z(l_z), .in_a(l_a),
    .rd_addr(late_addr), .rd_z(late_z_rd),
    .out_vld(out_vld), .out_x(out_x), .out_y(out_y),
    .out_pass(out_pass), .out_stage(stage_q),
    .wb_vld(wb_vld), .wb_addr(wb_addr), .wb_z(wb_z)
  );

  assign out_stage = stage_q;

endmodule

// File: rtl/zd_chk.sv
module zd_chk #(
  parameter int TEX_LAT = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       clr,
  input logic       in_vld,
  input logic       early_kill,
  input logic       tex_req,
  input logic       out_vld,
  input logic       out_pass,
  input logic [1:0] out_stage,
  input logic       wr_en
);
  int unsigned inflight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= 0;
    else        inflight <= inflight + 32'(in_vld) - 32'(out_vld);
  end

  // R3: an early-killed fragment never reaches the texel fetch
  assert_no_fetch_dead_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && early_kill) |=> !tex_req);

  // R3: an early survivor always fetches on the next cycle
  assert_fetch_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !early_kill) |=> tex_req);

  // R6: only a passing verdict commits a depth write
  assert_write_on_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (out_vld && out_pass && out_stage == 2'd0));

  // R7: never more fragments in flight than the pipeline holds
  assert_inflight_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 32'(TEX_LAT + 1));

  // R7: no verdict without a fragment in flight
  assert_no_phantom_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (inflight > 0));

  // R8: clear only while the pipeline is empty
  assert_clear_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> (!in_vld && inflight == 0));

endmodule

bind zdefer_top zd_chk #(.TEX_LAT(TEX_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(in_vld),
  .early_kill(early_kill), .tex_req(tex_req), .out_vld(out_vld),
  .out_pass(out_pass), .out_stage(out_stage), .wr_en(wb_vld)
);

// File: tb/tb_zdefer_top.sv
module tb_zdefer_top;
  localparam int XW = 5, YW = 5, DW = 16, ABW = 8, LAT = 4;
  localparam int NPIX = 1 << (XW + YW);

  logic clk, rst_n, clr, in_vld;
  logic [XW-1:0] in_x;  logic [YW-1:0] in_y;
  logic [DW-1:0] in_z;  logic [ABW-1:0] in_alpha;
  logic tex_req; logic [XW-1:0] tex_x; logic [YW-1:0] tex_y;
  logic out_vld; logic [XW-1:0] out_x; logic [YW-1:0] out_y;
  logic out_pass; logic [1:0] out_stage;

  zdefer_top #(.XW(XW), .YW(YW), .DW(DW), .ABW(ABW), .TEX_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(in_vld), .in_x(in_x), .in_y(in_y),
    .in_z(in_z), .in_alpha(in_alpha), .tex_req(tex_req), .tex_x(tex_x), .tex_y(tex_y),
    .out_vld(out_vld), .out_x(out_x), .out_y(out_y), .out_pass(out_pass),
    .out_stage(out_stage));

  initial clk = 0;
  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int due; int x; int y; int stage; string tag; } ev_t;
  typedef struct { int t; int a; int z; } wr_t;
  ev_t outq[$];
  ev_t texq[$];
  wr_t pend[$];
  int  cmt [NPIX];
  int  seqd[NPIX];
  int  total = 0, bad = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic check_outputs();
    if (outq.size() > 0 && outq[0].due == cyc) begin
      ev_t e = outq.pop_front();
      chk(out_vld === 1'b1, e.tag, "out_vld", int'(out_vld), 1);
      chk(int'(out_x) == e.x, e.tag, "out_x", int'(out_x), e.x);
      chk(int'(out_y) == e.y, e.tag, "out_y", int'(out_y), e.y);
      chk(int'(out_stage) == e.stage, e.tag, "out_stage", int'(out_stage), e.stage);
      chk(out_pass == (e.stage == 0), e.tag, "out_pass", int'(out_pass), int'(e.stage == 0));
    end else if (out_vld !== 1'b0) begin
      chk(0, "R7", "spurious out_vld", int'(out_vld), 0);
    end
    if (texq.size() > 0 && texq[0].due == cyc) begin
      ev_t e = texq.pop_front();
      chk(tex_req === 1'b1, "R3", "tex_req", int'(tex_req), 1);
      chk(int'(tex_x) == e.x && int'(tex_y) == e.y, "R3", "tex_xy",
          int'({tex_y, tex_x}), (e.y << XW) | e.x);
    end else if (tex_req !== 1'b0) begin
      chk(0, "R3", "spurious tex_req", int'(tex_req), 0);
    end
  endtask

  task automatic model(int x, int y, int z, int a, string tag);
    int u = cyc;
    int ad = (y << XW) | x;
    int st;
    ev_t e;
    while (pend.size() > 0 && pend[0].t + LAT + 2 <= u) begin
      wr_t w = pend.pop_front();
      cmt[w.a] = w.z;
    end
    if (z >= cmt[ad]) st = 1;
    else begin
      e.due = u + 1; e.x = x; e.y = y; e.stage = 0; e.tag = "R3";
      texq.push_back(e);
      if (a == 0) st = 2;
      else if (z >= seqd[ad]) st = 3;
      else begin
        wr_t w;
        st = 0; seqd[ad] = z;
        w.t = u; w.a = ad; w.z = z;
        pend.push_back(w);
      end
    end
    e.due = u + LAT + 1; e.x = x; e.y = y; e.stage = st;
    if (tag != "") e.tag = tag;
    else case (st)
      0: e.tag = "R6";
      1: e.tag = "R2";
      2: e.tag = "R4";
      default: e.tag = "R5";
    endcase
    outq.push_back(e);
  endtask

  task automatic step(bit v, int x, int y, int z, int a, string tag, bit c = 0);
    @(negedge clk);
    check_outputs();
    in_vld = v; in_x = XW'(x); in_y = YW'(y); in_z = DW'(z); in_alpha = ABW'(a); clr = c;
    if (c) begin
      for (int i = 0; i < NPIX; i++) begin cmt[i] = 'hFFFF; seqd[i] = 'hFFFF; end
    end
    if (v) model(x, y, z, a, tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, "");
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(200000 * 10);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NPIX; i++) begin cmt[i] = 'hFFFF; seqd[i] = 'hFFFF; end
    rst_n = 0; clr = 0; in_vld = 0; in_x = 0; in_y = 0; in_z = 0; in_alpha = 0;
    repeat (3) @(negedge clk);
    chk(out_vld === 1'b0, "R1", "out_vld in reset", int'(out_vld), 0);
    chk(tex_req === 1'b0, "R1", "tex_req in reset", int'(tex_req), 0);
    rst_n = 1;
    idle(2);
    chk(out_vld === 1'b0 && tex_req === 1'b0, "R1", "idle after reset",
        int'({out_vld, tex_req}), 0);

    // R1: buffer reset to all ones
    step(1, 0, 0, 'hFFFE, 5, "R1");
    idle(8);

    // distinct pixels, some transparent
    for (int i = 1; i < 21; i++) step(1, i, 1, 1000 + i * 37, (i % 5 == 0) ? 0 : 200, "");
    idle(8);

    // R5: stale early test, late kill; bypass of uncommitted write
    step(1, 3, 3, 500, 9, "R6");
    step(1, 3, 3, 600, 9, "R5");
    step(1, 3, 3, 450, 9, "R6");
    step(1, 3, 3, 470, 9, "R5");
    step(1, 3, 3, 420, 9, "R6");
    idle(8);
    step(1, 3, 3, 430, 9, "R2");
    idle(8);

    // R9: equal depth fails, early and late
    step(1, 4, 4, 700, 1, "R6");
    idle(8);
    step(1, 4, 4, 700, 1, "R9");
    step(1, 5, 4, 800, 1, "R6");
    step(1, 5, 4, 800, 1, "R9");
    idle(8);

    // R4: transparent fragment does not write depth
    step(1, 5, 5, 300, 0, "R4");
    step(1, 5, 5, 900, 9, "R4");
    idle(8);
    step(1, 5, 5, 900, 9, "R2");
    idle(8);

    // R8: clear while idle
    step(0, 0, 0, 0, 0, "", 1);
    step(1, 3, 3, 'hFFFE, 1, "R8");
    step(1, 6, 6, 'hFFFF, 1, "R8");
    step(1, 4, 4, 'hFFF0, 1, "R8");
    idle(8);

    // random mix on a small corner
    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom_range(0, 9));
      if (r < 7)
        step(1, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
             int'($urandom_range(0, 'hFFFF)),
             ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(1, 255)), "");
      else idle(1);
    end
    idle(10);
    chk(outq.size() == 0 && texq.size() == 0, "R7", "all verdicts seen",
        outq.size() + texq.size(), 0);
    summary();
    $finish;
  end

endmodule